// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit repairs the 8-bit working-register value left after two packed-BCD operands have been added in binary, so that it again holds two valid decimal digits. Each 4-bit digit is examined on its own. A digit above nine, or one whose carry flag from the earlier addition is set, is raised by six. The lower digit uses the digit-carry flag and the upper digit uses the carry flag. The correction of one digit never carries into the other.

The unit executes a single one-word instruction over a repeating four-phase cycle: decode, operand read, execute and write-back. The corrected byte is always written to the register named by the instruction's address field. The destination-select bit decides whether it is also written back into the working register. Only the carry flag is updated. The digit-carry flag is not an output and keeps its value. Any other instruction word leaves every write enable low.

Top module: `bcd_adjust_unit`

## Requirements
- R1: An instruction matches only when bits [15:9] equal 7'b0010111. Bit 8 is the destination select and bits [7:0] are the target register address. Any other pattern in bits [15:9] keeps `rf_we`, `w_we` and `c_we` low in every phase.
- R2: The low result digit is the low input digit plus 6, truncated to 4 bits, when that digit is above 9 or `dc_in` is 1. Otherwise the low digit passes through unchanged.
- R3: The high result digit is the high input digit plus 6, truncated to 4 bits, when that digit is above 9 or `c_in` is 1. Otherwise it passes through unchanged. The low-digit correction never changes the high digit.
- R4: The new carry `c_out` is 1 when the high digit was corrected. Otherwise it equals `c_in`. `c_we` is asserted together with `rf_we`.
- R5: `rf_addr` equals instruction bits [7:0]. With select 0, both `rf_we` and `w_we` are asserted and `w_wdata` equals `rf_wdata`. With select 1, only `rf_we` is asserted.
- R6: `phase` counts 0, 1, 2, 3 and then wraps to 0, advancing by one on every clock.
- R7: The instruction is captured at the clock edge that ends phase 0. Operands and flags are captured at the edge that ends phase 1. The result is registered at the edge that ends phase 2. The write enables are high only during phase 3.
- R8: An input of 0xA5 with both flags clear gives 0x05 with carry 1. An input of 0xCE with both flags clear gives 0x24 with carry 1.
- R9: While `rst_n` is low at a clock edge, `phase` returns to 0 and all write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| wreg_in | input | 8 | Working-register value, sampled at the end of phase 1 |
| c_in | input | 1 | Prior carry flag, sampled at the end of phase 1 |
| dc_in | input | 1 | Prior digit-carry flag, sampled at the end of phase 1 |
| phase | output | 2 | Current phase, 0 to 3 |
| rf_we | output | 1 | Register-file write enable, phase 3 only |
| rf_addr | output | 8 | Register-file write address |
| rf_wdata | output | 8 | Corrected byte for the register file |
| w_we | output | 1 | Working-register write enable |
| w_wdata | output | 8 | Corrected byte for the working register |
| c_we | output | 1 | Carry flag write enable |
| c_out | output | 1 | Updated carry flag |

## Verification
The bench applies a stimulus only while `phase` reads 0 and holds it through phase 1. Three clock edges then separate the stimulus from its results: the instruction register, the operand register and the result register. Every result check is therefore taken at the falling edge that falls inside phase 3, which is three falling edges after the stimulus was driven. At the phase 1 falling edge of selected operations, the bench also confirms that every enable is still low. It sweeps all 256 working values against all four flag combinations with alternating destination selects, and it sweeps every non-matching opcode pattern. The expected bytes are computed digit by digit in the bench.

// File: rtl/bcd_adj_pkg.sv
// Package: shared sizes, opcode constant and phase encoding for the
// decimal adjust unit. Assumes an 8-bit datapath made of 4-bit digits.
package bcd_adj_pkg;
    localparam int INSTR_W = 16;
    localparam int DATA_W  = 8;
    localparam int DIGIT_W = 4;
    localparam int ADDR_W  = 8;
    localparam int OPC_W   = INSTR_W - ADDR_W - 1;
    localparam logic [OPC_W-1:0] OPC_DEC_ADJ = 7'b0010111;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_EXEC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;
endpackage

// File: rtl/bcd_phase_seq.sv
// Module: four-phase sequencer. Advances one phase per clock and wraps
// after the write phase. Assumes reset is synchronous and active low.
module bcd_phase_seq
    import bcd_adj_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_q
);
    phase_e phase_d;

    // Purpose: choose the phase that follows the current one.
    always_comb begin
        unique case (phase_q)
            PH_DECODE: phase_d = PH_READ;
            PH_READ:   phase_d = PH_EXEC;
            PH_EXEC:   phase_d = PH_WRITE;
            default:   phase_d = PH_DECODE;
        endcase
    end

    // Purpose: hold the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_DECODE;
        else        phase_q <= phase_d;
    end

    AST_PHASE_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_WRITE |=> phase_q == PH_DECODE); // R6
endmodule

// File: rtl/bcd_digit_fix.sv
// Module: corrects one decimal digit. It adds the wrap offset when the
// digit exceeds LIMIT or when the forcing flag is set. The sum is
// truncated to the digit width, and `wrapped` reports a carry past it.
// Assumes LIMIT is below 2**DIGIT_W - 1.
module bcd_digit_fix #(
    parameter int DIGIT_W = 4,
    parameter int LIMIT   = 9
) (
    input  logic [DIGIT_W-1:0] digit_in,
    input  logic               force_fix,
    output logic [DIGIT_W-1:0] digit_out,
    output logic               wrapped
);
    localparam int ADJ = (1 << DIGIT_W) - LIMIT - 1;
    localparam logic [DIGIT_W:0] ADJ_V   = ADJ[DIGIT_W:0];
    localparam logic [DIGIT_W:0] LIMIT_V = LIMIT[DIGIT_W:0];

    logic             apply;
    logic [DIGIT_W:0] sum;

    // Purpose: decide on the correction and form the truncated digit.
    always_comb begin
        apply     = force_fix || ({1'b0, digit_in} > LIMIT_V);
        sum       = {1'b0, digit_in} + (apply ? ADJ_V : '0);
        digit_out = sum[DIGIT_W-1:0];
        wrapped   = sum[DIGIT_W];
    end

    // Purpose: an out-of-range digit must always wrap past the digit width.
    always_comb begin
        AST_BIG_DIGIT_WRAPS: assert (!({1'b0, digit_in} > LIMIT_V) || wrapped); // R2
    end
endmodule

// File: rtl/bcd_adjust_unit.sv
// Module: top of the packed-BCD decimal adjust unit. It decodes the
// instruction in phase 0, samples the operands in phase 1 and registers the
// corrected byte and carry in phase 2. It raises the write enables in
// phase 3. Assumes the adder result and flags are held stable from phase 0
// through phase 1.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] wreg_in,
    input  logic          c_in,
    input  logic          dc_in,
    output logic [1:0]    phase,
    output logic          rf_we,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          w_we,
    output logic [DW-1:0] w_wdata,
    output logic          c_we,
    output logic          c_out
);
    localparam int NDIG = DW / DIGIT_W;
    localparam int TOP  = NDIG - 1;

    phase_e        phase_q;
    logic          dec_hit, dec_dst;
    logic [AW-1:0] dec_addr;
    logic [DW-1:0] w_cap;
    logic          c_cap, dc_cap;
    logic [DW-1:0] fixed;
    logic [NDIG-1:0] wrap_all;
    logic          c_next;
    logic [DW-1:0] res_q;
    logic          c_res_q;
    logic          wr_now;

    bcd_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_q (phase_q)
    );

    // Purpose: latch the decoded instruction at the end of the decode phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_hit  <= 1'b0;
            dec_dst  <= 1'b0;
            dec_addr <= '0;
        end else if (phase_q == PH_DECODE) begin
            dec_hit  <= (instr[IW-1:AW+1] == OPC_DEC_ADJ);
            dec_dst  <= instr[AW];
            dec_addr <= instr[AW-1:0];
        end
    end

    // Purpose: capture the working value and flags at the end of the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_cap  <= '0;
            c_cap  <= 1'b0;
            dc_cap <= 1'b0;
        end else if (phase_q == PH_READ) begin
            w_cap  <= wreg_in;
            c_cap  <= c_in;
            dc_cap <= dc_in;
        end
    end

    // One corrector per digit; the lowest digit is forced by DC, the top by C.
    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic force_g;
        if (g == 0) begin : g_lo
            assign force_g = dc_cap;
        end else if (g == TOP) begin : g_hi
            assign force_g = c_cap;
        end else begin : g_mid
            assign force_g = 1'b0;
        end
        bcd_digit_fix #(.DIGIT_W(DIGIT_W), .LIMIT(9)) u_fix (
            .digit_in  (w_cap[g*DIGIT_W +: DIGIT_W]),
            .force_fix (force_g),
            .digit_out (fixed[g*DIGIT_W +: DIGIT_W]),
            .wrapped   (wrap_all[g])
        );
    end

    // Purpose: a corrected top digit sets carry; otherwise carry is kept.
    always_comb begin
        c_next = c_cap | wrap_all[TOP];
    end

    // Purpose: register the corrected byte and carry at the end of execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            c_res_q <= 1'b0;
        end else if (phase_q == PH_EXEC) begin
            res_q   <= fixed;
            c_res_q <= c_next;
        end
    end

    // Purpose: drive the write ports during the write phase only.
    always_comb begin
        wr_now   = (phase_q == PH_WRITE);
        rf_we    = wr_now && dec_hit;
        w_we     = rf_we && !dec_dst;
        c_we     = rf_we;
        rf_addr  = dec_addr;
        rf_wdata = res_q;
        w_wdata  = res_q;
        c_out    = c_res_q;
        phase    = phase_q;
    end

    AST_WRITES_IN_Q4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || w_we || c_we) |-> phase_q == PH_WRITE); // R7
    AST_WREG_WITH_RF: assert property (@(posedge clk) disable iff (!rst_n)
        w_we |-> rf_we); // R5
    AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXEC && c_cap) |=> c_res_q); // R4
    AST_NO_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXEC && wrap_all[0] && !c_cap && w_cap[DW-1:DW-DIGIT_W] < 4'd10)
        |=> res_q[DW-1:DW-DIGIT_W] == $past(w_cap[DW-1:DW-DIGIT_W])); // R3
endmodule

// File: tb/bcd_adjust_unit_bench.sv
`timescale 1ns/1ps
module bcd_adjust_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic [7:0]  wreg_in = '0;
    logic        c_in = 1'b0, dc_in = 1'b0;
    logic [1:0]  phase;
    logic        rf_we, w_we, c_we, c_out;
    logic [7:0]  rf_addr, rf_wdata, w_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bcd_adjust_unit u_bcd_adjust_unit (
        .clk(clk), .rst_n(rst_n), .instr(instr), .wreg_in(wreg_in),
        .c_in(c_in), .dc_in(dc_in), .phase(phase), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .w_we(w_we),
        .w_wdata(w_wdata), .c_we(c_we), .c_out(c_out)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {carry, high digit, low digit} computed from R2, R3 and R4.
    function automatic logic [8:0] ref_adj(input logic [7:0] w, input logic c, input logic dc);
        int lo = int'(w[3:0]);
        int hi = int'(w[7:4]);
        logic cn = c;
        if (lo > 9 || dc) lo = (lo + 6) % 16;
        if (hi > 9 || c) begin
            hi = (hi + 6) % 16;
            cn = 1'b1;
        end
        return {cn, 4'(hi), 4'(lo)};
    endfunction

    // Drive one operation in phase 0 and return at the falling edge inside phase 3.
    task automatic run_op(input logic [15:0] iw, input logic [7:0] w, input logic c,
                          input logic dc, input bit peek);
        do @(negedge clk); while (phase != 2'd0);
        instr = iw; wreg_in = w; c_in = c; dc_in = dc;
        @(negedge clk);
        if (peek) chk(!rf_we && !w_we && !c_we && phase == 2'd1, "R7 enables low in phase 1",
                      {rf_we, w_we, c_we}, 0);
        @(negedge clk);
        @(negedge clk);
        chk(phase == 2'd3, "R7 result phase", phase, 3);
    endtask

    task automatic check_hit(input logic [15:0] iw, input logic [7:0] w, input logic c,
                             input logic dc);
        logic [8:0] e = ref_adj(w, c, dc);
        chk(rf_we == 1'b1, "R1 rf_we on match", rf_we, 1);
        chk(rf_addr == iw[7:0], "R5 rf_addr", rf_addr, iw[7:0]);
        chk(rf_wdata[3:0] == e[3:0], "R2 low digit", rf_wdata[3:0], e[3:0]);
        chk(rf_wdata[7:4] == e[7:4], "R3 high digit", rf_wdata[7:4], e[7:4]);
        chk(c_we == 1'b1 && c_out == e[8], "R4 carry", {c_we, c_out}, {1'b1, e[8]});
        chk(w_we == !iw[8], "R5 working write select", w_we, !iw[8]);
        if (!iw[8]) chk(w_wdata == e[7:0], "R5 working data", w_wdata, e[7:0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [1:0] prev;
        // R9: reset state.
        repeat (3) @(negedge clk);
        chk(phase == 2'd0, "R9 reset phase", phase, 0);
        chk(!rf_we && !w_we && !c_we, "R9 reset enables", {rf_we, w_we, c_we}, 0);
        rst_n = 1'b1;
        // R6: phase sequence.
        prev = phase;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(phase == prev + 2'd1, "R6 phase step", phase, prev + 2'd1);
            prev = phase;
        end
        // R8: worked examples, destination both.
        run_op(16'h2E10, 8'hA5, 1'b0, 1'b0, 1'b1);
        chk(rf_wdata == 8'h05 && c_out, "R8 0xA5", {c_out, rf_wdata}, 9'h105);
        chk(w_we && w_wdata == 8'h05, "R8 0xA5 working", {w_we, w_wdata}, 9'h105);
        run_op(16'h2E11, 8'hCE, 1'b0, 1'b0, 1'b1);
        chk(rf_wdata == 8'h24 && c_out, "R8 0xCE", {c_out, rf_wdata}, 9'h124);
        // R2 R3 R4 R5: all working values against all flag pairs.
        for (int w = 0; w < 256; w++) begin
            for (int f = 0; f < 4; f++) begin
                logic [15:0] iw;
                iw = {7'b0010111, 1'(w + f), 8'(w ^ 8'h5A)};
                run_op(iw, 8'(w), f[1], f[0], (w % 64) == 0);
                check_hit(iw, 8'(w), f[1], f[0]);
            end
        end
        // R1: every other opcode pattern writes nothing.
        for (int op = 0; op < 128; op++) begin
            if (op != 7'b0010111) begin
                run_op({7'(op), 1'b0, 8'h33}, 8'hAA, 1'b1, 1'b1, 1'b0);
                chk(!rf_we && !w_we && !c_we, "R1 no write on other opcode",
                    {rf_we, w_we, c_we}, 0);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule